// File: doc/BRIEF.md
# Quadrature Encoder Command Sender

This block watches eight raw input lines that carry four quadrature rotary encoders, two lines per encoder. Each line is brought into the clock domain through a short flop chain. The block notices when a synchronized line changes and checks whether the partner line of the same encoder is high. If so, it turns the event into a fixed one-byte command for the encoder and direction that moved. When more than one event is found in the same cycle, a fixed priority picks exactly one of them.

The command byte goes out over a transmit-only SPI master link. The select line is driven low for the whole byte. The clock idles high, the receiver samples on each falling edge, and the byte goes least significant bit first. The block runs one transfer at a time. Events that arrive while a transfer is running are discarded, and none are queued.

Top module: `quad_cmd_spi`

## Requirements
- R1: While and after reset, with no event, `spi_ss_n` is 1, `spi_sck` is 1, `spi_mosi` is 0 and `busy` is 0. SCK stays high whenever select is high.
- R2: Lines pair as (7,6), (5,4), (3,2), (1,0). A change on a line while its partner line is high is an event. The command is 28 × (8 − line number): line 7 → 28, 6 → 56, 5 → 84, 4 → 112, 3 → 140, 2 → 168, 1 → 196, 0 → 224.
- R3: A line change while the partner line is low starts no transfer.
- R4: When several events occur in the same cycle, only the one on the highest-numbered line is sent.
- R5: `spi_ss_n` falls on the 4th rising clock edge after an input change, counting the first edge that samples the new input value.
- R6: Each frame has exactly 8 SCK falling edges. MOSI is stable while SCK is low. On the k-th falling edge (k = 0..7), MOSI carries bit k of the command, so the LSB goes first.
- R7: SCK falling edges inside a frame are 8 system clocks apart: SCK is low for 4 clocks and high for 4 clocks.
- R8: Select stays low for exactly 68 clocks per frame. `busy` equals the inverse of `spi_ss_n` in every cycle.
- R9: An event that occurs while a frame is in progress is dropped. It is never sent, neither during that frame nor after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_in | input | 8 | Raw encoder lines, asynchronous |
| spi_sck | output | 1 | SPI clock, idles high |
| spi_mosi | output | 1 | SPI serial data out |
| spi_ss_n | output | 1 | Active-low select framing one byte |
| busy | output | 1 | High while a frame is in progress |

## Verification
Results arrive at fixed delays after a stimulus. A new input value reaches the second synchronizer flop on the 2nd edge and the registered decode on the 3rd, and select falls on the 4th edge. The first SCK fall comes 4 clocks after that, and the later falls follow every 8 clocks. Select rises 68 clocks after it fell. The bench drives inputs on falling clock edges and counts rising edges until it sees select low, so the 4-edge latency is checked exactly. It then counts falling edges while select is low. A monitor reads MOSI at each SCK falling edge and records the number of clocks between falls. Checks that nothing is sent wait well past the point where a frame would have begun and then compare the frame count at the ports.

// File: rtl/qcs_pkg.sv
package qcs_pkg;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_SHIFT = 1'b1
  } tx_state_t;

  // Command byte for priority slot idx (0 = highest line)
  function automatic int unsigned slot_code(input int unsigned idx, input int unsigned step);
    return step * (idx + 1);
  endfunction

endpackage

// File: rtl/qcs_sync.sv
module qcs_sync #(
  parameter int LINES  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl,
  output logic [LINES-1:0] chg
);

  logic [LINES-1:0] stg [STAGES];
  logic [LINES-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= stg[STAGES-1];
  end

  assign lvl = stg[STAGES-1];
  assign chg = stg[STAGES-1] ^ prev;

endmodule

// File: rtl/qcs_decode.sv
module qcs_decode
  import qcs_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int CODE_W    = 8,
  parameter int CODE_STEP = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  lvl,
  input  logic [LINES-1:0]  chg,
  output logic              cmd_vld,
  output logic [CODE_W-1:0] cmd
);

  // hit[j]: slot j covers line LINES-1-j, partner is the other line of its pair
  logic [LINES-1:0] hit;

  for (genvar j = 0; j < LINES; j++) begin : g_slot
    localparam int LN = LINES - 1 - j;
    localparam int PT = LN ^ 1;
    assign hit[j] = chg[LN] & lvl[PT];
  end

  logic [CODE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int j = LINES - 1; j >= 0; j--) begin
      if (hit[j]) pick = CODE_W'(slot_code(j, CODE_STEP));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_vld <= 1'b0;
      cmd     <= '0;
    end else begin
      cmd_vld <= (pick != '0);
      cmd     <= pick;
    end
  end

endmodule

// File: rtl/qcs_spi_tx.sv
module qcs_spi_tx
  import qcs_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] data,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy
);

  localparam int HALF = CLK_DIV / 2;
  localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int STEPS = 2 * CODE_W;
  localparam int SCW  = $clog2(STEPS + 1);
  localparam logic [HCW-1:0] TICK_END = HCW'(HALF - 1);
  localparam logic [SCW-1:0] LAST     = SCW'(STEPS);

  tx_state_t         state;
  logic [HCW-1:0]    tick;
  logic [SCW-1:0]    step;
  logic [CODE_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      tick  <= '0;
      step  <= '0;
      shreg <= '0;
      sck   <= 1'b1;
      mosi  <= 1'b0;
      ss_n  <= 1'b1;
      busy  <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (start) begin
            state <= TX_SHIFT;
            ss_n  <= 1'b0;
            busy  <= 1'b1;
            mosi  <= data[0];
            shreg <= data >> 1;
            tick  <= '0;
            step  <= '0;
          end
        end
        TX_SHIFT: begin
          if (tick == TICK_END) begin
            tick <= '0;
            if (step == LAST) begin
              state <= TX_IDLE;
              ss_n  <= 1'b1;
              busy  <= 1'b0;
              mosi  <= 1'b0;
              sck   <= 1'b1;
            end else begin
              step <= step + 1'b1;
              if (!step[0]) begin
                sck <= 1'b0;
              end else begin
                sck   <= 1'b1;
                mosi  <= shreg[0];
                shreg <= shreg >> 1;
              end
            end
          end else begin
            tick <= tick + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/quad_cmd_spi.sv
module quad_cmd_spi #(
  parameter int NUM_ENC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_W      = 8,
  parameter int CODE_STEP   = 28,
  parameter int CLK_DIV     = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*NUM_ENC-1:0] enc_in,
  output logic                 spi_sck,
  output logic                 spi_mosi,
  output logic                 spi_ss_n,
  output logic                 busy
);

  localparam int LINES = 2 * NUM_ENC;

  logic [LINES-1:0]  lvl;
  logic [LINES-1:0]  chg;
  logic              cmd_vld;
  logic [CODE_W-1:0] cmd_code;

  qcs_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (enc_in),
    .lvl (lvl),
    .chg (chg)
  );

  qcs_decode #(.LINES(LINES), .CODE_W(CODE_W), .CODE_STEP(CODE_STEP)) dec_i (
    .clk     (clk),
    .rst     (rst),
    .lvl     (lvl),
    .chg     (chg),
    .cmd_vld (cmd_vld),
    .cmd     (cmd_code)
  );

  qcs_spi_tx #(.CODE_W(CODE_W), .CLK_DIV(CLK_DIV)) tx_i (
    .clk   (clk),
    .rst   (rst),
    .start (cmd_vld),
    .data  (cmd_code),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .ss_n  (spi_ss_n),
    .busy  (busy)
  );

endmodule

// File: rtl/qcs_checker.sv
module qcs_checker #(
  parameter int CODE_W    = 8,
  parameter int CODE_STEP = 28,
  parameter int CLK_DIV   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sck,
  input logic              mosi,
  input logic              ss_n,
  input logic              busy,
  input logic              cmd_vld,
  input logic [CODE_W-1:0] cmd
);

  localparam int FRAME_CYC = (2 * CODE_W + 1) * (CLK_DIV / 2);

  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || ss_n) low_cnt <= '0;
    else             low_cnt <= low_cnt + 16'd1;
  end

  // R1: clock at idle level whenever deselected
  a_r1_sck_idle: assert property (@(posedge clk) disable iff (rst) ss_n |-> sck);

  // R2: decoded commands are nonzero multiples of the step
  a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |-> (cmd != '0) && ((int'(cmd) % CODE_STEP) == 0));

  // R6: data held steady through the low phase of SCK
  a_r6_mosi_stable: assert property (@(posedge clk) disable iff (rst)
    (!ss_n && !sck && $past(!sck) && $past(!ss_n)) |-> $stable(mosi));

  // R8: frame never longer than its fixed length
  a_r8_frame_max: assert property (@(posedge clk) disable iff (rst)
    !ss_n |-> (low_cnt < 16'(FRAME_CYC)));

  // R8: frame ends exactly at its fixed length
  a_r8_frame_len: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_n) |-> (low_cnt == 16'(FRAME_CYC)));

  // R8: busy mirrors select
  a_r8_busy_ss: assert property (@(posedge clk) disable iff (rst) busy == !ss_n);

endmodule

bind quad_cmd_spi qcs_checker #(
  .CODE_W    (CODE_W),
  .CODE_STEP (CODE_STEP),
  .CLK_DIV   (CLK_DIV)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .sck     (spi_sck),
  .mosi    (spi_mosi),
  .ss_n    (spi_ss_n),
  .busy    (busy),
  .cmd_vld (cmd_vld),
  .cmd     (cmd_code)
);

// File: tb/quad_cmd_spi_tb_top.sv
`timescale 1ns/1ps
module quad_cmd_spi_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] enc_in = 8'h00;
  logic       spi_sck, spi_mosi, spi_ss_n, busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  quad_cmd_spi dut_i (
    .clk      (clk),
    .rst      (rst),
    .enc_in   (enc_in),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .spi_ss_n (spi_ss_n),
    .busy     (busy)
  );

  // Port monitor
  int         cyc = 0;
  int         frames = 0;
  int         rx_bits = 0;
  logic [7:0] rx_byte = 8'h00;
  int         last_fall = 0;
  int         gap_err = 0;

  always @(posedge clk) cyc++;

  always @(negedge spi_ss_n) begin
    frames++;
    rx_bits = 0;
    rx_byte = 8'h00;
  end

  always @(negedge spi_sck) begin
    if (!spi_ss_n) begin
      if (rx_bits > 0 && (cyc - last_fall) != 8) gap_err++;
      if (rx_bits < 8) rx_byte[rx_bits] = spi_mosi;
      rx_bits++;
      last_fall = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a value that should yield a frame carrying exp_code
  task automatic t_event(input logic [7:0] val, input int exp_code, input string req);
    int n = 0;
    int m = 0;
    int busy_bad = 0;
    @(negedge clk);
    enc_in = val;
    while (spi_ss_n && n < 20) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    check(n == 4, "R5 select latency", n, 4);
    gap_err = 0;
    while (!spi_ss_n && m < 200) begin
      if (busy !== 1'b1) busy_bad++;
      @(negedge clk);
      m++;
    end
    if (busy !== 1'b0) busy_bad++;
    check(m == 68, "R8 select low cycles", m, 68);
    check(busy_bad == 0, "R8 busy vs select", busy_bad, 0);
    check(rx_bits == 8, "R6 falling edges per frame", rx_bits, 8);
    check(gap_err == 0, "R7 SCK period", gap_err, 0);
    check(int'(rx_byte) == exp_code, req, int'(rx_byte), exp_code);
    check(spi_sck == 1'b1, "R1 SCK idle after frame", spi_sck, 1);
    repeat (6) @(negedge clk);
  endtask

  // Drive a value that should yield no frame
  task automatic t_none(input logic [7:0] val, input string req);
    int f0;
    @(negedge clk);
    f0 = frames;
    enc_in = val;
    repeat (30) @(negedge clk);
    check(frames == f0, req, frames - f0, 0);
    check(spi_ss_n == 1'b1 && spi_sck == 1'b1, req, {spi_ss_n, spi_sck}, 3);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(spi_ss_n == 1'b1, "R1 ss_n in reset", spi_ss_n, 1);
    check(spi_sck == 1'b1, "R1 sck in reset", spi_sck, 1);
    check(spi_mosi == 1'b0, "R1 mosi in reset", spi_mosi, 0);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(frames == 0 && spi_ss_n && spi_sck && !spi_mosi && !busy,
          "R1 idle after reset", frames, 0);
  endtask

  task automatic t_codes;
    t_none (8'h40, "R3 line6 rise, line7 low");
    t_event(8'hC0, 28,  "R2 line7 code");
    t_event(8'h80, 56,  "R2 line6 code");
    t_none (8'h00, "R3 line7 fall, line6 low");
    t_none (8'h10, "R3 line4 rise");
    t_event(8'h30, 84,  "R2 line5 code");
    t_event(8'h20, 112, "R2 line4 code");
    t_none (8'h00, "R3 line5 fall");
    t_none (8'h04, "R3 line2 rise");
    t_event(8'h0C, 140, "R2 line3 code");
    t_event(8'h08, 168, "R2 line2 code");
    t_none (8'h00, "R3 line3 fall");
    t_none (8'h01, "R3 line0 rise");
    t_event(8'h03, 196, "R2 line1 code");
    t_event(8'h02, 224, "R2 line0 code");
    t_none (8'h00, "R3 line1 fall");
  endtask

  task automatic t_priority;
    t_none (8'h50, "R3 even lines rise");
    t_event(8'hF0, 28,  "R4 line7 over line5");
    t_none (8'h00, "R3 all fall");
    t_none (8'h05, "R3 even lines rise low pair");
    t_event(8'h0F, 140, "R4 line3 over line1");
    t_none (8'h00, "R3 all fall low pair");
    t_none (8'h44, "R3 lines 6 and 2 rise");
    t_event(8'hCC, 28,  "R4 line7 over line3");
    t_none (8'h00, "R3 all fall mixed");
  endtask

  task automatic t_drop;
    int f0;
    t_none(8'h40, "R3 setup for drop");
    @(negedge clk);
    f0 = frames;
    enc_in = 8'hC0;
    repeat (24) @(negedge clk);
    check(!spi_ss_n, "R9 frame running", spi_ss_n, 0);
    enc_in = 8'h80;
    repeat (150) @(negedge clk);
    check(frames == f0 + 1, "R9 event during frame dropped", frames - f0, 1);
    check(int'(rx_byte) == 28, "R9 frame byte intact", int'(rx_byte), 28);
    t_none(8'h00, "R3 cleanup after drop");
  endtask

  initial begin
    t_reset();
    t_codes();
    t_priority();
    t_drop();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule